// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of token flags that two processors share: one processor on the left port, one on the right port. Software uses the flags to agree on which side may use a shared resource. The flags drive no hardware resource themselves. A side asks for a token by writing a flag and then reads the same flag to learn whether the request was granted. If the other side already holds the token, the request stays pending. The requester can keep reading until the token arrives, or it can withdraw the request. When the owner releases a flag that has a pending request from the other side, the token moves to that side by itself.

Each port has its own semaphore select, a write strobe, a flag address, one write data bit and a registered read word. Every access finishes in the cycle it is presented, and there is no stall signal, so neither processor ever waits. A read returns its result on the clock edge after the read cycle.

Top module: `two_port_sem_bank`

## Requirements
- R1: The bank has NUM_FLAGS independent flags (default 8), selected by an address of $clog2(NUM_FLAGS) bits. Writing one flag never changes the ownership or pending state of any other flag.
- R2: A selected write with write bit = 0 requests the token. If the flag is free, the writer owns it after the clock edge of that write. A selected read (sel=1, we=0) returns all-zero rdata on the edge that ends the read cycle when the reading side owns the addressed flag.
- R3: A read returns all-ones rdata when the reading side does not own the addressed flag, whether the flag is free or held by the other side.
- R4: A flag is never owned by both sides at once.
- R5: A request for a flag the other side holds does not grant ownership and stays pending. A write with write bit = 1 releases the flag if the writer owns it, or withdraws the writer's pending request if it does not.
- R6: When the owner releases a flag while the other side has a pending request, the other side owns the flag from the next cycle, with no further write.
- R7: When both sides request a free flag in the same cycle, the left side gets the token and the right request stays pending.
- R8: A port with sel=0 changes no flag, whatever its other inputs are. Its rdata holds its last value, and it also holds during writes.
- R9: After a synchronous active-high reset, every flag is free, no request is pending, and both rdata outputs are all ones.
- R10: A read in the same cycle as a write from the other port returns the ownership state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left semaphore select |
| l_we | input | 1 | Left write strobe (0 = read) |
| l_addr | input | ADDR_W | Left flag address |
| l_wbit | input | 1 | Left write bit: 0 requests, 1 releases or withdraws |
| l_rdata | output | DATA_W | Left registered read word |
| r_sel | input | 1 | Right semaphore select |
| r_we | input | 1 | Right write strobe (0 = read) |
| r_addr | input | ADDR_W | Right flag address |
| r_wbit | input | 1 | Right write bit: 0 requests, 1 releases or withdraws |
| r_rdata | output | DATA_W | Right registered read word |

## Verification
The bench builds the bank with its default parameters: eight flags, a 3-bit address and a 16-bit read word. With only eight flags, random addresses from both ports fall on the same flag often. Because of this, same-cycle ties, requests against a held flag, and releases with a request pending all happen many times, alongside the directed sequences. The 16-bit read word makes sure the all-zero and all-ones encodings cover every bit of rdata.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;
  localparam int unsigned DEF_FLAGS  = 8;
  localparam int unsigned DEF_DATA_W = 16;
  // write-bit encoding
  localparam logic WBIT_REQUEST = 1'b0;
  localparam logic WBIT_RELEASE = 1'b1;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned ADDR_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 sel,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wbit,
  output logic [NUM_FLAGS-1:0] req_o,
  output logic [NUM_FLAGS-1:0] rel_o,
  output logic                 rd_stb_o
);
  import sem_bank_pkg::*;

  logic wr_stb;
  assign wr_stb   = sel & we;
  assign rd_stb_o = sel & ~we;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
    logic hit;
    assign hit      = wr_stb && (addr == ADDR_W'(i));
    assign req_o[i] = hit && (wbit == WBIT_REQUEST);
    assign rel_o[i] = hit && (wbit == WBIT_RELEASE);
  end
endmodule

// File: rtl/sem_flag.sv
module sem_flag (
  input  logic clk,
  input  logic rst,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic own_l_o,
  output logic own_r_o
);
  logic req_l_q, req_r_q, own_l_q, own_r_q;
  logic req_l_n, req_r_n, keep_l, keep_r, own_l_n, own_r_n;

  always_comb begin
    req_l_n = l_req ? 1'b1 : (l_rel ? 1'b0 : req_l_q);
    req_r_n = r_req ? 1'b1 : (r_rel ? 1'b0 : req_r_q);
    keep_l  = own_l_q & req_l_n;
    keep_r  = own_r_q & req_r_n;
    // left wins a free flag; the owner keeps it while it still requests
    own_l_n = keep_l | (~keep_r & req_l_n);
    own_r_n = keep_r | (~keep_l & ~req_l_n & req_r_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
      own_l_q <= 1'b0;
      own_r_q <= 1'b0;
    end else begin
      req_l_q <= req_l_n;
      req_r_q <= req_r_n;
      own_l_q <= own_l_n;
      own_r_q <= own_r_n;
    end
  end

  assign own_l_o = own_l_q;
  assign own_r_o = own_r_q;

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    !(own_l_o && own_r_o)); // R4
  AST_FREE_GRANT_L: assert property (@(posedge clk) disable iff (rst)
    (!own_l_o && !own_r_o && l_req) |=> own_l_o); // R2
  AST_HELD_DENY_L: assert property (@(posedge clk) disable iff (rst)
    (own_r_o && l_req && !r_rel) |=> !own_l_o); // R5
  AST_HELD_DENY_R: assert property (@(posedge clk) disable iff (rst)
    (own_l_o && r_req && !l_rel) |=> !own_r_o); // R5
  AST_HANDOVER_R: assert property (@(posedge clk) disable iff (rst)
    (own_l_o && l_rel && req_r_q && !r_rel) |=> own_r_o); // R6
  AST_HANDOVER_L: assert property (@(posedge clk) disable iff (rst)
    (own_r_o && r_rel && req_l_q && !l_rel) |=> own_l_o); // R6
  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
    (!own_l_o && !own_r_o && l_req && r_req) |=> (own_l_o && !own_r_o)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!l_req && !l_rel && !r_req && !r_rel) |=> ($stable(own_l_o) && $stable(own_r_o))); // R1
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int unsigned NUM_FLAGS = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = $clog2(NUM_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_stb,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_FLAGS-1:0] own_vec,
  output logic [DATA_W-1:0]    rdata
);
  logic owned;
  assign owned = own_vec[addr];

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '1;
    else if (rd_stb) rdata <= owned ? '0 : '1;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rdata)); // R8
  AST_RD_OWNED: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && owned) |=> (rdata == '0)); // R2
  AST_RD_NOT_OWNED: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !owned) |=> (rdata == '1)); // R3
endmodule

// File: rtl/two_port_sem_bank.sv
module two_port_sem_bank #(
  parameter int unsigned NUM_FLAGS = sem_bank_pkg::DEF_FLAGS,
  parameter int unsigned DATA_W    = sem_bank_pkg::DEF_DATA_W,
  parameter int unsigned ADDR_W    = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wbit,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wbit,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel, own_l, own_r;
  logic l_rd, r_rd;

  sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_l (
    .sel(l_sel), .we(l_we), .addr(l_addr), .wbit(l_wbit),
    .req_o(l_req), .rel_o(l_rel), .rd_stb_o(l_rd));

  sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_r (
    .sel(r_sel), .we(r_we), .addr(r_addr), .wbit(r_wbit),
    .req_o(r_req), .rel_o(r_rel), .rd_stb_o(r_rd));

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    sem_flag u_flag (
      .clk(clk), .rst(rst),
      .l_req(l_req[i]), .l_rel(l_rel[i]),
      .r_req(r_req[i]), .r_rel(r_rel[i]),
      .own_l_o(own_l[i]), .own_r_o(own_r[i]));
  end

  sem_read_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_l (
    .clk(clk), .rst(rst), .rd_stb(l_rd), .addr(l_addr),
    .own_vec(own_l), .rdata(l_rdata));

  sem_read_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_r (
    .clk(clk), .rst(rst), .rd_stb(r_rd), .addr(r_addr),
    .own_vec(own_r), .rdata(r_rdata));

  AST_RESET_FREE: assert property (@(posedge clk)
    rst |=> (own_l == '0 && own_r == '0 && l_rdata == '1 && r_rdata == '1)); // R9
  AST_UNSEL_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!l_sel && !r_sel) |=> ($stable(own_l) && $stable(own_r))); // R8
endmodule

// File: tb/two_port_sem_bank_test.sv
`timescale 1ns/1ps
module two_port_sem_bank_test;
  localparam int NF = 8;
  localparam int AW = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel = 0, l_we = 0, l_wbit = 1, r_sel = 0, r_we = 0, r_wbit = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_rdata, r_rdata;

  always #5 clk = ~clk;

  two_port_sem_bank uut (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_wbit(l_wbit), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_wbit(r_wbit), .r_rdata(r_rdata));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit m_ownl[NF], m_ownr[NF], m_reql[NF], m_reqr[NF];
  logic [DW-1:0] e_l = '1, e_r = '1;

  function automatic logic [DW-1:0] rd_word(bit owned);
    return owned ? {DW{1'b0}} : {DW{1'b1}};
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive, predict from the model, clock, compare both ports
  task automatic step(bit ls, bit lw, logic [AW-1:0] la, bit lb,
                      bit rs, bit rw, logic [AW-1:0] ra, bit rb, string tag);
    l_sel = ls; l_we = lw; l_addr = la; l_wbit = lb;
    r_sel = rs; r_we = rw; r_addr = ra; r_wbit = rb;
    if (ls && !lw) e_l = rd_word(m_ownl[la]);
    if (rs && !rw) e_r = rd_word(m_ownr[ra]);
    if (ls && lw) m_reql[la] = !lb;
    if (rs && rw) m_reqr[ra] = !rb;
    for (int i = 0; i < NF; i++) begin
      if (m_ownl[i] && !m_reql[i]) m_ownl[i] = 0;
      if (m_ownr[i] && !m_reqr[i]) m_ownr[i] = 0;
      if (!m_ownl[i] && !m_ownr[i]) begin
        if (m_reql[i])      m_ownl[i] = 1;
        else if (m_reqr[i]) m_ownr[i] = 1;
      end
    end
    @(posedge clk); #1;
    check({tag, " left"}, l_rdata, e_l);
    check({tag, " right"}, r_rdata, e_r);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5EAF0C1;
    void'($urandom(seed));
    for (int i = 0; i < NF; i++) begin
      m_ownl[i] = 0; m_ownr[i] = 0; m_reql[i] = 0; m_reqr[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R9 reset left", l_rdata, '1);
    check("R9 reset right", r_rdata, '1);
    for (int a = 0; a < NF; a++) step(1, 0, AW'(a), 0, 1, 0, AW'(a), 0, "R9 free after reset");

    // R2: grant on free flag, owner reads zeros; R3: other side reads ones
    step(1, 1, 3, 0, 0, 0, 0, 0, "R2 request");
    step(1, 0, 3, 0, 1, 0, 3, 0, "R2 R3 readback");
    // R5: request against held flag stays pending
    step(0, 0, 0, 0, 1, 1, 3, 0, "R5 blocked request");
    step(1, 0, 3, 0, 1, 0, 3, 0, "R5 still denied");
    // R6: release hands over to pending right
    step(1, 1, 3, 1, 0, 0, 0, 0, "R6 release");
    step(1, 0, 3, 0, 1, 0, 3, 0, "R6 handover");
    // R5 withdraw: left pending, withdraws, right releases -> free
    step(1, 1, 3, 0, 0, 0, 0, 0, "R5 pend left");
    step(1, 1, 3, 1, 0, 0, 0, 0, "R5 withdraw left");
    step(0, 0, 0, 0, 1, 1, 3, 1, "R5 release right");
    step(1, 0, 3, 0, 1, 0, 3, 0, "R5 flag free");
    // R7: tie on a free flag goes left
    step(1, 1, 5, 0, 1, 1, 5, 0, "R7 tie");
    step(1, 0, 5, 0, 1, 0, 5, 0, "R7 left wins");
    // R1: other flags untouched
    for (int a = 0; a < NF; a++) step(1, 0, AW'(a), 0, 1, 0, AW'(a), 0, "R1 independence");
    // R8: unselected writes do nothing, rdata holds
    step(0, 1, 5, 1, 0, 1, 2, 0, "R8 unselected write");
    step(1, 0, 5, 0, 1, 0, 2, 0, "R8 state kept");
    // R10: read sees state before a same-cycle write from the other side
    step(1, 0, 5, 0, 1, 1, 6, 0, "R10 setup");
    step(1, 1, 5, 1, 1, 0, 5, 0, "R10 read old state");
    step(1, 0, 5, 0, 1, 0, 5, 0, "R10 after handover");

    for (int n = 0; n < 4000; n++) begin
      bit ls = ($urandom % 4) != 0;
      bit rs = ($urandom % 4) != 0;
      step(ls, 1'($urandom), AW'($urandom), 1'($urandom),
           rs, 1'($urandom), AW'($urandom), 1'($urandom), "R1 R4 random");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8 idle end");
    done = 1;
    summary();
    $finish;
  end
endmodule